// File: doc/BRIEF.md
# Warm Reset Handshake Controller

This block sequences chip resets on behalf of software. A write to its control register either starts a cold reset at once or starts a warm reset. Before a warm reset, the block can first ask four neighbouring agents to quiesce: the SDRAM controller enters self-refresh, the FPGA fabric completes a handshake, the configuration manager idles its output clock, and the trace unit stalls its AXI master. Each agent has its own request and acknowledge wire. Acknowledges come from other clock domains and are synchronized inside the block.

The handshakes run one at a time, in a fixed order. A stage that is not enabled is skipped. A stage whose acknowledge never arrives is abandoned after a bounded wait. Only then is the warm reset pulse driven. The requests are held through the first warm-reset cycle and are released while warm reset is still asserted. If the trace stall was part of the sequence, a sticky stall-pending flag keeps the trace master stalled after the warm reset ends, until software clears the flag. Register fields survive a warm reset. A cold request or the asynchronous reset input clears them.

Top module: `rsthk_ctrl`

## Requirements
- R1: The control register at offset 0x04 holds the four stage enables in bits [3:0]: bit 0 SDRAM self-refresh, bit 1 clock idle, bit 2 FPGA handshake, bit 3 trace stall. They read back as written. Writing 1 to bit 9 requests a warm reset and writing 1 to bit 8 requests a cold reset. Bits 8 and 9 always read 0.
- R2: After a warm request, stages are requested in the order SDRAM (bit 0), FPGA (bit 2), clock idle (bit 1), trace (bit 3). Each stage's request is held until warm reset. A stage is requested only after the previous enabled stage has finished: with a prompt acknowledge, the next enabled request rises 4 cycles later, plus 1 cycle per disabled stage skipped between them. A disabled stage is never requested.
- R3: `warm_rst_o` rises only after every enabled stage has finished. It rises 3 cycles after the last enabled request if that stage was acknowledged, plus 1 cycle per disabled stage after it.
- R4: A stage whose acknowledge never arrives is abandoned after TMO_CYC cycles (default 1024). The next enabled request then rises TMO_CYC+1 cycles after the stalled one, and the sequence still reaches warm reset.
- R5: `warm_rst_o` stays high for exactly RST_CYC cycles (default 16). In its first cycle every enabled request is still high. From the second cycle on, all requests are low.
- R6: The acknowledge register at offset 0x18 shows in bits [3:0] the synchronized acknowledge of each stage, gated by that stage's request. Bit 8 is the stall-pending flag. All other bits read 0.
- R7: When warm reset is entered with the trace enable set, the stall-pending flag becomes 1. `trace_stall_o` is high whenever the flag is 1.
- R8: Writing 1 to bit 8 at offset 0x18 clears the stall-pending flag and drops `trace_stall_o`. Writing 0 there has no effect.
- R9: A warm reset leaves the control fields unchanged.
- R10: A cold request at once drops all requests and abandons any sequence. It clears every field to 0 and drives `cold_rst_o` for RST_CYC cycles, never together with `warm_rst_o`. `rst_n` low clears the same state asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset, used for both read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |
| hs_req_o | output | 4 | Handshake requests: bit 0 SDRAM, 1 clock idle, 2 FPGA, 3 trace stall |
| hs_ack_i | input | 4 | Asynchronous handshake acknowledges, same bit order |
| warm_rst_o | output | 1 | Warm reset pulse |
| cold_rst_o | output | 1 | Cold reset pulse |
| trace_stall_o | output | 1 | Stall for the trace AXI master |

## Verification
The assertions watch, on every cycle, the request ordering rule, the release of requests only under a reset pulse, the exact warm pulse width, the mutual exclusion of the two reset outputs, and the clean state on cold entry. They also watch the coupling of the stall flag to `trace_stall_o` and the zero bits of the acknowledge register. Some behaviours can only be shown by bench scenarios, because they depend on how the acknowledge wires behave over whole sequences. These are the exact cycle spacing between requests, the timeout length, the survival of fields across warm reset, and the write-one-to-clear rule. The bench sweeps all sixteen enable patterns with responsive agents, runs one sequence with a silent FPGA agent, and interrupts a stuck sequence with a cold request.

// File: rtl/rsthk_pkg.sv
package rsthk_pkg;

  localparam int unsigned N_STG = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HSK,
    ST_WARM,
    ST_COLD
  } seq_st_e;

  // sequence position -> request/acknowledge bit
  function automatic logic [1:0] stg_bit(input logic [1:0] pos);
    case (pos)
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return pos;
    endcase
  endfunction

endpackage

// File: rtl/rsthk_rst_sync.sv
module rsthk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_ns = sh_q[1];
endmodule

// File: rtl/rsthk_sync.sv
module rsthk_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rsthk_seq.sv
module rsthk_seq
  import rsthk_pkg::*;
#(
  parameter int unsigned TMO_CYC = 1024,
  parameter int unsigned RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold_go,
  input  logic             warm_go,
  input  logic [N_STG-1:0] en_i,
  input  logic [N_STG-1:0] ack_s,
  output logic [N_STG-1:0] req_o,
  output logic             warm_rst_o,
  output logic             cold_rst_o,
  output logic             warm_enter
);
  localparam int unsigned TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  seq_st_e          st_q, st_d;
  logic [1:0]       pos_q, pos_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [N_STG-1:0] req_q, req_d;
  logic             adv, enter_d;
  logic [1:0]       cur;

  assign cur = stg_bit(pos_q);

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    tmr_d   = tmr_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    adv     = 1'b0;
    enter_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (warm_go) begin
          st_d  = ST_HSK;
          pos_d = 2'd0;
          tmr_d = '0;
        end
      end
      ST_HSK: begin
        if (!en_i[cur])                               adv = 1'b1;
        else if (!req_q[cur]) begin
          req_d[cur] = 1'b1;
          tmr_d      = '0;
        end
        else if (ack_s[cur] || tmr_q == TW'(TMO_CYC-1)) adv = 1'b1;
        else                                          tmr_d = tmr_q + 1'b1;
        if (adv) begin
          tmr_d = '0;
          if (pos_q == 2'(N_STG-1)) begin
            st_d    = ST_WARM;
            cnt_d   = '0;
            enter_d = 1'b1;
          end else begin
            pos_d = pos_q + 2'd1;
          end
        end
      end
      ST_WARM, ST_COLD: begin
        req_d = '0;
        if (cnt_q == CW'(RST_CYC-1)) st_d  = ST_IDLE;
        else                         cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cold_go) begin
      st_d    = ST_COLD;
      cnt_d   = '0;
      req_d   = '0;
      enter_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pos_q <= '0;
      tmr_q <= '0;
      cnt_q <= '0;
      req_q <= '0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
      tmr_q <= tmr_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o      = req_q;
  assign warm_rst_o = (st_q == ST_WARM);
  assign cold_rst_o = (st_q == ST_COLD);
  assign warm_enter = enter_d;
endmodule

// File: rtl/rsthk_ctrl.sv
module rsthk_ctrl
  import rsthk_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 32,
  parameter logic [7:0]  CTRL_OFF    = 8'h04,
  parameter logic [7:0]  ACK_OFF     = 8'h18,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_CYC     = 1024,
  parameter int unsigned RST_CYC     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [3:0]    hs_req_o,
  input  logic [3:0]    hs_ack_i,
  output logic          warm_rst_o,
  output logic          cold_rst_o,
  output logic          trace_stall_o
);
  localparam int unsigned COLD_B  = 8;
  localparam int unsigned WARM_B  = 9;
  localparam int unsigned STALL_B = 8;
  localparam int unsigned TRC_STG = 3;

  logic             rst_ns;
  logic [N_STG-1:0] ack_s;
  logic [N_STG-1:0] en_q, en_d;
  logic             stall_q, stall_d;
  logic             wr_ctrl, wr_ack, cold_go, warm_go, warm_enter;
  logic             wdata_unused;

  assign wdata_unused = ^{reg_wdata[DW-1:WARM_B+1], reg_wdata[COLD_B-1:N_STG]};

  rsthk_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  rsthk_sync #(.W(N_STG), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_ns), .din(hs_ack_i), .dout(ack_s)
  );

  assign wr_ctrl = reg_we && (reg_addr == AW'(CTRL_OFF));
  assign wr_ack  = reg_we && (reg_addr == AW'(ACK_OFF));
  assign cold_go = wr_ctrl && reg_wdata[COLD_B];
  assign warm_go = wr_ctrl && reg_wdata[WARM_B] && !reg_wdata[COLD_B];

  rsthk_seq #(.TMO_CYC(TMO_CYC), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_ns), .cold_go(cold_go), .warm_go(warm_go),
    .en_i(en_q), .ack_s(ack_s), .req_o(hs_req_o),
    .warm_rst_o(warm_rst_o), .cold_rst_o(cold_rst_o), .warm_enter(warm_enter)
  );

  always_comb begin
    en_d    = en_q;
    stall_d = stall_q;
    if (wr_ctrl) en_d = reg_wdata[N_STG-1:0];
    if (wr_ack && reg_wdata[STALL_B]) stall_d = 1'b0;
    if (warm_enter && en_q[TRC_STG])  stall_d = 1'b1;
    if (cold_go) begin
      en_d    = '0;
      stall_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q    <= '0;
      stall_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      stall_q <= stall_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(CTRL_OFF)) begin
      reg_rdata[N_STG-1:0] = en_q;
    end else if (reg_addr == AW'(ACK_OFF)) begin
      reg_rdata[N_STG-1:0] = ack_s & hs_req_o;
      reg_rdata[STALL_B]   = stall_q;
    end
  end

  assign trace_stall_o = hs_req_o[TRC_STG] | stall_q;
endmodule

// File: rtl/rsthk_ctrl_chk.sv
module rsthk_ctrl_chk
  import rsthk_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 32,
  parameter logic [7:0]  ACK_OFF = 8'h18,
  parameter int unsigned RST_CYC = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    en_q,
  input logic          stall_q,
  input logic [3:0]    hs_req_o,
  input logic          warm_rst_o,
  input logic          cold_rst_o,
  input logic          trace_stall_o,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata
);
  localparam int unsigned WW = $clog2(RST_CYC + 2) + 1;
  logic [WW-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wcnt_q <= '0;
    else if (warm_rst_o) wcnt_q <= wcnt_q + 1'b1;
    else                 wcnt_q <= '0;
  end

  for (genvar p = 1; p < 4; p++) begin : g_ord
    localparam logic [1:0] CB = stg_bit(2'(p));
    localparam logic [1:0] PB = stg_bit(2'(p - 1));
    AST_REQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      hs_req_o[CB] |-> (hs_req_o[PB] || !en_q[PB])); // R2
  end

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hs_req_o) != 4'b0 && hs_req_o == 4'b0) |-> (warm_rst_o || cold_rst_o)); // R5
  AST_WARM_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warm_rst_o) |-> (wcnt_q == WW'(RST_CYC) || cold_rst_o)); // R5
  AST_RESET_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(warm_rst_o && cold_rst_o)); // R10
  AST_COLD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_rst_o) |-> (hs_req_o == 4'b0 && en_q == 4'b0 && !stall_q)); // R10
  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(warm_rst_o) && $past(en_q[3])) |-> stall_q); // R7
  AST_STALL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> trace_stall_o); // R7
  AST_ACK_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(ACK_OFF)) |-> (reg_rdata[DW-1:9] == '0 && reg_rdata[7:4] == 4'b0)); // R6
endmodule

bind rsthk_ctrl rsthk_ctrl_chk #(
  .AW(AW), .DW(DW), .ACK_OFF(ACK_OFF), .RST_CYC(RST_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_ns), .en_q(en_q), .stall_q(stall_q),
  .hs_req_o(hs_req_o), .warm_rst_o(warm_rst_o), .cold_rst_o(cold_rst_o),
  .trace_stall_o(trace_stall_o), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/rsthk_ctrl_tb.sv
`timescale 1ns/1ps
module rsthk_ctrl_tb;
  localparam int TMO = 1024;
  localparam int RST = 16;
  localparam logic [7:0] CTRL = 8'h04;
  localparam logic [7:0] ACKR = 8'h18;
  localparam int P2B [4] = '{0, 2, 1, 3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  hs_req_o;
  logic [3:0]  hs_ack_i = '0;
  logic [3:0]  ack_mask = 4'hF;
  logic        warm_rst_o, cold_rst_o, trace_stall_o;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  rsthk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hs_req_o(hs_req_o),
    .hs_ack_i(hs_ack_i), .warm_rst_o(warm_rst_o), .cold_rst_o(cold_rst_o),
    .trace_stall_o(trace_stall_o)
  );

  // agents: acknowledge follows request one half cycle later, unless silenced
  initial forever begin
    @(negedge clk);
    hs_ack_i = hs_req_o & ack_mask;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic run_warm(input logic [3:0] en, input logic [3:0] msk);
    int rise [4];
    int wrise, prev, wlen;
    logic [31:0] d;
    for (int p = 0; p < 4; p++) rise[p] = -1;
    wrise = -1;
    ack_mask = msk;
    wr(CTRL, 32'h200 | {28'b0, en});
    reg_addr = ACKR;
    for (int t = 0; t < 6000 && wrise < 0; t++) begin
      @(negedge clk);
      #1;
      for (int p = 0; p < 4; p++)
        if (rise[p] < 0 && hs_req_o[P2B[p]]) rise[p] = t;
      if (warm_rst_o) wrise = t;
      if (msk == 4'b1011 && rise[1] >= 0 && t == rise[1] + 10) begin
        chk(hs_req_o == 4'b0101, "R4 requests held while FPGA stage waits", {28'b0, hs_req_o}, 32'h5);
        chk(reg_rdata == 32'h1, "R6 status shows only acknowledged stage", reg_rdata, 32'h1);
      end
    end
    chk(wrise >= 0, "R3 warm reset reached", wrise, 0);
    prev = -1;
    for (int p = 0; p < 4; p++) begin
      if (en[P2B[p]]) begin
        chk(rise[p] >= 0, "R2 enabled stage requested", rise[p], p);
        if (prev >= 0)
          chk(rise[p] - rise[prev] == (msk[P2B[prev]] ? 4 : TMO + 1) + (p - prev - 1),
              msk[P2B[prev]] ? "R2 request spacing" : "R4 timeout spacing",
              rise[p] - rise[prev], (msk[P2B[prev]] ? 4 : TMO + 1) + (p - prev - 1));
        prev = p;
      end else begin
        chk(rise[p] < 0, "R2 disabled stage never requested", rise[p], -1);
      end
    end
    if (prev >= 0)
      chk(wrise - rise[prev] == (msk[P2B[prev]] ? 3 : TMO) + (3 - prev), "R3 warm after last stage",
          wrise - rise[prev], (msk[P2B[prev]] ? 3 : TMO) + (3 - prev));
    chk(hs_req_o == en, "R5 requests held in first warm cycle", {28'b0, hs_req_o}, {28'b0, en});
    wlen = 1;
    for (int k = 0; k < 100 && warm_rst_o; k++) begin
      @(negedge clk);
      #1;
      if (warm_rst_o) begin
        wlen++;
        if (hs_req_o != 4'b0)
          chk(1'b0, "R5 requests released during warm", {28'b0, hs_req_o}, 0);
      end
    end
    chk(wlen == RST, "R5 warm width", wlen, RST);
    repeat (5) @(negedge clk);
    rd(ACKR, d);
    chk(d == {23'b0, en[3], 8'b0}, "R7 R6 status after warm", d, {23'b0, en[3], 8'b0});
    chk(trace_stall_o == en[3], "R7 trace stall output", trace_stall_o, en[3]);
    rd(CTRL, d);
    chk(d == {28'b0, en}, "R9 enables survive warm", d, {28'b0, en});
    if (en[3]) begin
      wr(ACKR, 32'h0);
      rd(ACKR, d);
      chk(d == 32'h100 && trace_stall_o, "R8 write 0 keeps stall", d, 32'h100);
      wr(ACKR, 32'h100);
      rd(ACKR, d);
      chk(d == 32'h0 && !trace_stall_o, "R8 write 1 clears stall", d, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] d;
    int clen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(CTRL, d);
    chk(d == 0, "R10 control after reset", d, 0);
    rd(ACKR, d);
    chk(d == 0, "R10 status after reset", d, 0);
    chk(!warm_rst_o && !cold_rst_o && hs_req_o == 0 && !trace_stall_o, "R10 outputs after reset",
        {27'b0, warm_rst_o, cold_rst_o, trace_stall_o, 2'b0}, 0);

    wr(CTRL, 32'h5);
    rd(CTRL, d);
    chk(d == 32'h5 && !warm_rst_o, "R1 enable readback", d, 32'h5);
    wr(CTRL, 32'h0);

    // every enable pattern, agents responsive
    for (int e = 0; e < 16; e++) run_warm(4'(e), 4'hF);

    // FPGA agent silent: timeout path
    run_warm(4'hF, 4'b1011);

    // cold request interrupts a stuck sequence and clears a pending stall
    ack_mask = 4'hF;
    wr(CTRL, 32'h208);
    repeat (60) @(negedge clk);
    rd(ACKR, d);
    chk(d == 32'h100, "R7 stall pending before cold", d, 32'h100);
    ack_mask = 4'h0;
    wr(CTRL, 32'h20F);
    repeat (20) @(negedge clk);
    chk(hs_req_o == 4'b0001, "R2 waiting on SDRAM stage", {28'b0, hs_req_o}, 1);
    wr(CTRL, 32'h300);
    #1;
    chk(hs_req_o == 0 && cold_rst_o && !warm_rst_o, "R10 cold aborts sequence",
        {27'b0, hs_req_o, cold_rst_o}, 1);
    rd(CTRL, d);
    chk(d == 0, "R1 R10 control cleared by cold", d, 0);
    rd(ACKR, d);
    chk(d == 0 && !trace_stall_o, "R10 stall cleared by cold", d, 0);
    clen = 1;
    for (int k = 0; k < 100 && cold_rst_o; k++) begin
      @(negedge clk);
      #1;
      if (cold_rst_o) clen++;
    end
    chk(clen == RST, "R10 cold width", clen, RST);
    finish_sim();
  end
endmodule